// File: doc/BRIEF.md
# Skip-Capable In-Order Instruction Queue

This block is a short in-order queue placed between two pipeline stages. When an instruction arrives, it decides whether the instruction may jump straight to the stage two steps ahead. If so, the instruction skips both the queue and the stage in between. If not, the instruction has to be queued. The decision depends on three things: the queue must be empty, the target stage must not be stalled for the instruction's thread, and the target stage's input buffer must have at least one free slot. Every instruction that skips is counted.

Each queued entry holds a thread identifier, a sequence number and an opaque payload. The block supports these operations:
- An append at the tail, which is refused when the queue is full.
- Deletion of the first entry that matches a given thread and sequence number, wherever it sits.
- A pop of the head. The head entry is always visible on the outputs without removing it.
- A squash. It removes every entry of one thread that is younger than a given sequence number.

After deletions the surviving entries close up toward the head in the same cycle, so the head is always slot zero.

Top module: `skipq_buffer`

## Requirements
- R1: `byp_grant` is high in the same cycle only when `req_valid` is high, the queue holds no entries, `ds_blocked[req_tid]` is low and `ds_free` is nonzero.
- R2: `next_stage` equals `req_stage`+2 when `byp_grant` is high and `req_stage`+1 otherwise. `sched_ins_stage` is always `req_stage`+1 and `sched_rm_stage` is always `req_stage`+2. All of these are modulo 2^STAGE_W.
- R3: `byp_count` increases by one in the cycle after each cycle in which `byp_grant` is high, and holds otherwise. It is zero after reset.
- R4: An append (`ins_valid`) is accepted, with `ins_accepted` high in the same cycle, only when the occupancy at the start of the cycle is below DEPTH. A refused append leaves the contents unchanged.
- R5: Accepted entries are appended after all surviving entries, so arrival order is kept. `head_valid`, `head_tid`, `head_seq` and `head_payload` show the oldest entry without removing it.
- R6: `pop_valid` removes the head entry. A pop on an empty queue has no effect.
- R7: `rm_valid` deletes only the first entry, counted from the head, whose thread equals `rm_tid` and whose sequence number equals `rm_seq`. The others keep their order. If nothing matches, nothing changes.
- R8: `sq_valid` removes every entry whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq`, using an unsigned compare. Entries of other threads, and entries of that thread with a sequence number not greater than `sq_seq`, stay in order.
- R9: An append in the same cycle as a squash is dropped, with `ins_accepted` low, when `ins_tid` equals `sq_tid` and `ins_seq` is greater than `sq_seq`. Otherwise the append follows R4.
- R10: After reset the queue is empty: `occupancy` is 0 and `head_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Skip decision requested this cycle |
| req_tid | input | TID_W | Thread of the requesting instruction |
| req_stage | input | STAGE_W | Stage the requesting instruction is in |
| ds_blocked | input | 2^TID_W | Per-thread stall flags of the stage two ahead |
| ds_free | input | FREE_W | Free slots in the input buffer of the stage two ahead |
| byp_grant | output | 1 | Skip granted |
| next_stage | output | STAGE_W | Stage the instruction goes to next |
| sched_ins_stage | output | STAGE_W | Stage at which a refused instruction is queued |
| sched_rm_stage | output | STAGE_W | Stage at which a refused instruction leaves the queue |
| byp_count | output | BYP_W | Number of granted skips |
| ins_valid | input | 1 | Append request |
| ins_tid | input | TID_W | Thread of the appended entry |
| ins_seq | input | SEQ_W | Sequence number of the appended entry |
| ins_payload | input | PAY_W | Payload of the appended entry |
| ins_accepted | output | 1 | Append taken this cycle |
| rm_valid | input | 1 | Delete-by-identity request |
| rm_tid | input | TID_W | Thread of the entry to delete |
| rm_seq | input | SEQ_W | Sequence number of the entry to delete |
| pop_valid | input | 1 | Remove the head entry |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Squash point; younger entries are removed |
| head_valid | output | 1 | Head entry present |
| head_tid | output | TID_W | Thread of the head entry |
| head_seq | output | SEQ_W | Sequence number of the head entry |
| head_payload | output | PAY_W | Payload of the head entry |
| occupancy | output | $clog2(DEPTH+1) | Number of entries held |

## Verification
The skip decision is driven with each of its three conditions failing on its own. One case stalls only a different thread, which shows that the stall flag is taken per thread and not globally. The queue is filled to capacity and then offered one more entry, to separate "refused when full" from "overwrites the tail".

Deletion is tried on a middle entry, on an identity that appears twice, and on an identity that does not exist. These show that exactly the first match goes and that the order of the rest is kept. The squash is run on a mix of threads that includes an entry of the squashed thread equal to the squash point, so that the strict compare is exercised. It is also paired with same-cycle appends that fall on each side of the squash point.

// File: rtl/skipq_pkg.sv
package skipq_pkg;

    localparam int TID_W = 2;
    localparam int SEQ_W = 8;
    localparam int PAY_W = 16;
    localparam int NUM_THREADS = 1 << TID_W;

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        logic [PAY_W-1:0] payload;
    } entry_t;

endpackage

// File: rtl/skipq_bypass.sv
module skipq_bypass #(
    parameter int STAGE_W = 3,
    parameter int FREE_W  = 3
) (
    input  logic               req_valid,
    input  logic               queue_empty,
    input  logic               target_blocked,
    input  logic [FREE_W-1:0]  target_free,
    input  logic [STAGE_W-1:0] cur_stage,
    output logic               grant,
    output logic [STAGE_W-1:0] next_stage,
    output logic [STAGE_W-1:0] ins_stage,
    output logic [STAGE_W-1:0] rm_stage
);

    localparam logic [STAGE_W-1:0] ONE = STAGE_W'(1);
    localparam logic [STAGE_W-1:0] TWO = STAGE_W'(2);

    always_comb begin
        grant      = req_valid && queue_empty && !target_blocked && (target_free != '0);
        ins_stage  = cur_stage + ONE;
        rm_stage   = cur_stage + TWO;
        next_stage = grant ? rm_stage : ins_stage;
    end

endmodule

// File: rtl/skipq_match.sv
module skipq_match
    import skipq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  entry_t [DEPTH-1:0] ent,
    input  logic   [DEPTH-1:0] vld,
    input  logic               pop_valid,
    input  logic               sq_valid,
    input  logic [TID_W-1:0]   sq_tid,
    input  logic [SEQ_W-1:0]   sq_seq,
    input  logic               rm_valid,
    input  logic [TID_W-1:0]   rm_tid,
    input  logic [SEQ_W-1:0]   rm_seq,
    output logic [DEPTH-1:0]   keep
);

    logic [DEPTH-1:0] sq_hit;
    logic [DEPTH-1:0] pop_hit;
    logic [DEPTH-1:0] rm_cand;
    logic [DEPTH-1:0] rm_hit;

    // per-slot squash and identity compare
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign sq_hit[g] = vld[g] && sq_valid && (ent[g].tid == sq_tid)
                           && (ent[g].seq > sq_seq);
        if (g == 0) begin : g_head
            assign pop_hit[g] = pop_valid && vld[g];
        end else begin : g_rest
            assign pop_hit[g] = 1'b0;
        end
        assign rm_cand[g] = rm_valid && vld[g] && !sq_hit[g] && !pop_hit[g]
                            && (ent[g].tid == rm_tid) && (ent[g].seq == rm_seq);
    end

    // first candidate from the head wins
    always_comb begin
        logic found;
        found  = 1'b0;
        rm_hit = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rm_cand[i] && !found) begin
                rm_hit[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    assign keep = vld & ~sq_hit & ~pop_hit & ~rm_hit;

endmodule

// File: rtl/skipq_compact.sv
module skipq_compact
    import skipq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  entry_t [DEPTH-1:0]            ent,
    input  logic   [DEPTH-1:0]            keep,
    output entry_t [DEPTH-1:0]            packed_ent,
    output logic   [DEPTH-1:0]            packed_vld,
    output logic   [$clog2(DEPTH+1)-1:0]  kept_cnt
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // prefix sum of kept slots gives each survivor its destination
    logic [DEPTH:0][CNT_W-1:0] prefix;

    assign prefix[0] = '0;
    for (genvar g = 0; g < DEPTH; g++) begin : g_prefix
        assign prefix[g+1] = prefix[g] + CNT_W'(keep[g]);
    end

    always_comb begin
        packed_ent = '0;
        packed_vld = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                packed_ent[prefix[i][IDX_W-1:0]] = ent[i];
                packed_vld[prefix[i][IDX_W-1:0]] = 1'b1;
            end
        end
    end

    assign kept_cnt = prefix[DEPTH];

endmodule

// File: rtl/skipq_buffer.sv
module skipq_buffer
    import skipq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int STAGE_W = 3,
    parameter int FREE_W  = 3,
    parameter int BYP_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [TID_W-1:0]            req_tid,
    input  logic [STAGE_W-1:0]          req_stage,
    input  logic [NUM_THREADS-1:0]      ds_blocked,
    input  logic [FREE_W-1:0]           ds_free,
    output logic                        byp_grant,
    output logic [STAGE_W-1:0]          next_stage,
    output logic [STAGE_W-1:0]          sched_ins_stage,
    output logic [STAGE_W-1:0]          sched_rm_stage,
    output logic [BYP_W-1:0]            byp_count,
    input  logic                        ins_valid,
    input  logic [TID_W-1:0]            ins_tid,
    input  logic [SEQ_W-1:0]            ins_seq,
    input  logic [PAY_W-1:0]            ins_payload,
    output logic                        ins_accepted,
    input  logic                        rm_valid,
    input  logic [TID_W-1:0]            rm_tid,
    input  logic [SEQ_W-1:0]            rm_seq,
    input  logic                        pop_valid,
    input  logic                        sq_valid,
    input  logic [TID_W-1:0]            sq_tid,
    input  logic [SEQ_W-1:0]            sq_seq,
    output logic                        head_valid,
    output logic [TID_W-1:0]            head_tid,
    output logic [SEQ_W-1:0]            head_seq,
    output logic [PAY_W-1:0]            head_payload,
    output logic [$clog2(DEPTH+1)-1:0]  occupancy
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic   [DEPTH-1:0] vld;
        logic   [CNT_W-1:0] cnt;
        logic   [BYP_W-1:0] byp;
    } state_t;

    state_t state_d, state_q;

    logic [DEPTH-1:0]   keep;
    entry_t [DEPTH-1:0] packed_ent;
    logic [DEPTH-1:0]   packed_vld;
    logic [CNT_W-1:0]   kept_cnt;
    logic               ins_killed;

    skipq_bypass #(
        .STAGE_W (STAGE_W),
        .FREE_W  (FREE_W)
    ) u_bypass (
        .req_valid      (req_valid),
        .queue_empty    (state_q.cnt == '0),
        .target_blocked (ds_blocked[req_tid]),
        .target_free    (ds_free),
        .cur_stage      (req_stage),
        .grant          (byp_grant),
        .next_stage     (next_stage),
        .ins_stage      (sched_ins_stage),
        .rm_stage       (sched_rm_stage)
    );

    skipq_match #(
        .DEPTH (DEPTH)
    ) u_match (
        .ent       (state_q.ent),
        .vld       (state_q.vld),
        .pop_valid (pop_valid),
        .sq_valid  (sq_valid),
        .sq_tid    (sq_tid),
        .sq_seq    (sq_seq),
        .rm_valid  (rm_valid),
        .rm_tid    (rm_tid),
        .rm_seq    (rm_seq),
        .keep      (keep)
    );

    skipq_compact #(
        .DEPTH (DEPTH)
    ) u_compact (
        .ent        (state_q.ent),
        .keep       (keep),
        .packed_ent (packed_ent),
        .packed_vld (packed_vld),
        .kept_cnt   (kept_cnt)
    );

    // an incoming entry younger than a same-cycle squash of its thread is dropped
    assign ins_killed   = sq_valid && (ins_tid == sq_tid) && (ins_seq > sq_seq);
    assign ins_accepted = ins_valid && (state_q.cnt < CNT_W'(DEPTH)) && !ins_killed;

    always_comb begin
        state_d     = state_q;
        state_d.ent = packed_ent;
        state_d.vld = packed_vld;
        state_d.cnt = kept_cnt;
        if (ins_accepted) begin
            state_d.ent[kept_cnt[IDX_W-1:0]].tid     = ins_tid;
            state_d.ent[kept_cnt[IDX_W-1:0]].seq     = ins_seq;
            state_d.ent[kept_cnt[IDX_W-1:0]].payload = ins_payload;
            state_d.vld[kept_cnt[IDX_W-1:0]]         = 1'b1;
            state_d.cnt                              = kept_cnt + CNT_W'(1);
        end
        if (byp_grant) begin
            state_d.byp = state_q.byp + BYP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign byp_count    = state_q.byp;
    assign occupancy    = state_q.cnt;
    assign head_valid   = state_q.vld[0];
    assign head_tid     = state_q.ent[0].tid;
    assign head_seq     = state_q.ent[0].seq;
    assign head_payload = state_q.ent[0].payload;

endmodule

// File: rtl/skipq_buffer_chk.sv
module skipq_buffer_chk
    import skipq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int STAGE_W = 3,
    parameter int FREE_W  = 3,
    parameter int BYP_W   = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [TID_W-1:0]            req_tid,
    input logic [STAGE_W-1:0]          req_stage,
    input logic [NUM_THREADS-1:0]      ds_blocked,
    input logic [FREE_W-1:0]           ds_free,
    input logic                        byp_grant,
    input logic [STAGE_W-1:0]          next_stage,
    input logic [BYP_W-1:0]            byp_count,
    input logic                        ins_valid,
    input logic                        ins_accepted,
    input logic                        rm_valid,
    input logic                        pop_valid,
    input logic                        sq_valid,
    input logic [TID_W-1:0]            sq_tid,
    input logic [SEQ_W-1:0]            sq_seq,
    input logic                        head_valid,
    input logic [TID_W-1:0]            head_tid,
    input logic [SEQ_W-1:0]            head_seq,
    input logic [$clog2(DEPTH+1)-1:0]  occupancy
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_GRANT_COND: assert property (@(posedge clk) disable iff (!rst_n)
        byp_grant |-> (req_valid && occupancy == '0 && !ds_blocked[req_tid] && ds_free != '0)); // R1

    AST_SKIP_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        byp_grant |-> (next_stage == req_stage + STAGE_W'(2))); // R2

    AST_BYP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        byp_grant |=> (byp_count == $past(byp_count) + BYP_W'(1))); // R3

    AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_grant |=> $stable(byp_count)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R4

    AST_FULL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && occupancy == CNT_W'(DEPTH)) |-> !ins_accepted); // R4

    AST_APPEND_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_accepted && !pop_valid && !rm_valid && !sq_valid)
        |=> (occupancy == $past(occupancy) + CNT_W'(1))); // R5

    AST_HEAD_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid == (occupancy != '0)); // R5

    AST_SQUASH_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> !(head_valid && head_tid == $past(sq_tid) && head_seq > $past(sq_seq))); // R8

endmodule

bind skipq_buffer skipq_buffer_chk #(
    .DEPTH   (DEPTH),
    .STAGE_W (STAGE_W),
    .FREE_W  (FREE_W),
    .BYP_W   (BYP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_tid      (req_tid),
    .req_stage    (req_stage),
    .ds_blocked   (ds_blocked),
    .ds_free      (ds_free),
    .byp_grant    (byp_grant),
    .next_stage   (next_stage),
    .byp_count    (byp_count),
    .ins_valid    (ins_valid),
    .ins_accepted (ins_accepted),
    .rm_valid     (rm_valid),
    .pop_valid    (pop_valid),
    .sq_valid     (sq_valid),
    .sq_tid       (sq_tid),
    .sq_seq       (sq_seq),
    .head_valid   (head_valid),
    .head_tid     (head_tid),
    .head_seq     (head_seq),
    .occupancy    (occupancy)
);

// File: tb/skipq_buffer_test.sv
module skipq_buffer_test;
    import skipq_pkg::*;

    localparam int DEPTH   = 4;
    localparam int STAGE_W = 3;
    localparam int FREE_W  = 3;
    localparam int BYP_W   = 16;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic [TID_W-1:0]       req_tid = '0;
    logic [STAGE_W-1:0]     req_stage = '0;
    logic [NUM_THREADS-1:0] ds_blocked = '0;
    logic [FREE_W-1:0]      ds_free = '0;
    logic                   byp_grant;
    logic [STAGE_W-1:0]     next_stage, sched_ins_stage, sched_rm_stage;
    logic [BYP_W-1:0]       byp_count;
    logic                   ins_valid = 1'b0;
    logic [TID_W-1:0]       ins_tid = '0;
    logic [SEQ_W-1:0]       ins_seq = '0;
    logic [PAY_W-1:0]       ins_payload = '0;
    logic                   ins_accepted;
    logic                   rm_valid = 1'b0;
    logic [TID_W-1:0]       rm_tid = '0;
    logic [SEQ_W-1:0]       rm_seq = '0;
    logic                   pop_valid = 1'b0;
    logic                   sq_valid = 1'b0;
    logic [TID_W-1:0]       sq_tid = '0;
    logic [SEQ_W-1:0]       sq_seq = '0;
    logic                   head_valid;
    logic [TID_W-1:0]       head_tid;
    logic [SEQ_W-1:0]       head_seq;
    logic [PAY_W-1:0]       head_payload;
    logic [CNT_W-1:0]       occupancy;

    int checks = 0;
    int errors = 0;
    int exp_tid [8];
    int exp_seq [8];
    int grants  = 0;

    always #5 clk = ~clk;

    skipq_buffer #(
        .DEPTH(DEPTH), .STAGE_W(STAGE_W), .FREE_W(FREE_W), .BYP_W(BYP_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tid(req_tid), .req_stage(req_stage),
        .ds_blocked(ds_blocked), .ds_free(ds_free),
        .byp_grant(byp_grant), .next_stage(next_stage),
        .sched_ins_stage(sched_ins_stage), .sched_rm_stage(sched_rm_stage),
        .byp_count(byp_count),
        .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq),
        .ins_payload(ins_payload), .ins_accepted(ins_accepted),
        .rm_valid(rm_valid), .rm_tid(rm_tid), .rm_seq(rm_seq),
        .pop_valid(pop_valid),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .head_valid(head_valid), .head_tid(head_tid), .head_seq(head_seq),
        .head_payload(head_payload), .occupancy(occupancy)
    );

    function automatic int pay_of(int t, int s);
        return 16'h5000 + t * 256 + s;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; ins_valid = 0; rm_valid = 0; pop_valid = 0; sq_valid = 0;
    endtask

    task automatic put(int t, int s, int exp_acc, string req);
        ins_valid = 1; ins_tid = TID_W'(t); ins_seq = SEQ_W'(s); ins_payload = PAY_W'(pay_of(t, s));
        #1;
        check(req, "ins_accepted", int'(ins_accepted), exp_acc);
        tick();
    endtask

    task automatic drain(int n, string req);
        check(req, "occupancy before drain", int'(occupancy), n);
        for (int k = 0; k < n; k++) begin
            check(req, "head_valid", int'(head_valid), 1);
            check(req, "head_tid", int'(head_tid), exp_tid[k]);
            check(req, "head_seq", int'(head_seq), exp_seq[k]);
            check(req, "head_payload", int'(head_payload), pay_of(exp_tid[k], exp_seq[k]));
            pop_valid = 1;
            tick();
        end
        check(req, "occupancy after drain", int'(occupancy), 0);
    endtask

    task automatic t_reset();
        check("R10", "occupancy", int'(occupancy), 0);
        check("R10", "head_valid", int'(head_valid), 0);
        check("R3", "byp_count at reset", int'(byp_count), 0);
    endtask

    task automatic t_bypass();
        req_valid = 1; req_tid = 1; req_stage = 3; ds_blocked = '0; ds_free = 2;
        #1;
        check("R1", "grant all clear", int'(byp_grant), 1);
        check("R2", "next_stage granted", int'(next_stage), 5);
        tick(); grants++;
        check("R3", "byp_count after grant", int'(byp_count), grants);

        req_valid = 1; req_tid = 1; req_stage = 3; ds_blocked = 4'b0010; ds_free = 2;
        #1;
        check("R1", "grant own thread blocked", int'(byp_grant), 0);
        check("R2", "next_stage refused", int'(next_stage), 4);
        check("R2", "sched_ins_stage", int'(sched_ins_stage), 4);
        check("R2", "sched_rm_stage", int'(sched_rm_stage), 5);
        tick();
        check("R3", "byp_count hold", int'(byp_count), grants);

        req_valid = 1; req_tid = 1; req_stage = 7; ds_blocked = 4'b0001; ds_free = 1;
        #1;
        check("R1", "grant other thread blocked", int'(byp_grant), 1);
        check("R2", "next_stage wraps", int'(next_stage), 1);
        tick(); grants++;
        check("R3", "byp_count second grant", int'(byp_count), grants);

        req_valid = 1; req_tid = 2; req_stage = 0; ds_blocked = '0; ds_free = 0;
        #1;
        check("R1", "grant no free slot", int'(byp_grant), 0);
        tick();

        put(0, 1, 1, "R4");
        req_valid = 1; req_tid = 2; ds_free = 3;
        #1;
        check("R1", "grant queue not empty", int'(byp_grant), 0);
        tick();
        check("R3", "byp_count final", int'(byp_count), grants);
        exp_tid[0] = 0; exp_seq[0] = 1;
        drain(1, "R6");
    endtask

    task automatic t_fill();
        for (int k = 0; k < DEPTH; k++) begin
            put(k % 2, 10 + k, 1, "R4");
            exp_tid[k] = k % 2; exp_seq[k] = 10 + k;
        end
        check("R4", "occupancy full", int'(occupancy), DEPTH);
        put(3, 99, 0, "R4");
        check("R4", "occupancy after deny", int'(occupancy), DEPTH);
        check("R5", "peek head seq", int'(head_seq), 10);
        tick();
        check("R5", "peek keeps head", int'(head_seq), 10);
        drain(DEPTH, "R5");
        pop_valid = 1;
        tick();
        check("R6", "pop on empty", int'(occupancy), 0);
        check("R6", "head_valid empty", int'(head_valid), 0);
    endtask

    task automatic t_remove();
        put(0, 5, 1, "R7"); put(1, 6, 1, "R7"); put(2, 7, 1, "R7"); put(0, 5, 1, "R7");
        rm_valid = 1; rm_tid = 1; rm_seq = 6;
        tick();
        check("R7", "occupancy after middle remove", int'(occupancy), 3);
        rm_valid = 1; rm_tid = 0; rm_seq = 5;
        tick();
        rm_valid = 1; rm_tid = 3; rm_seq = 5;
        tick();
        check("R7", "occupancy after no match", int'(occupancy), 2);
        exp_tid[0] = 2; exp_seq[0] = 7;
        exp_tid[1] = 0; exp_seq[1] = 5;
        drain(2, "R7");
    endtask

    task automatic t_squash();
        put(0, 4, 1, "R8"); put(1, 9, 1, "R8"); put(0, 7, 1, "R8"); put(1, 3, 1, "R8");
        sq_valid = 1; sq_tid = 1; sq_seq = 3;
        tick();
        check("R8", "occupancy after squash", int'(occupancy), 3);
        exp_tid[0] = 0; exp_seq[0] = 4;
        exp_tid[1] = 0; exp_seq[1] = 7;
        exp_tid[2] = 1; exp_seq[2] = 3;
        drain(3, "R8");
    endtask

    task automatic t_squash_insert();
        put(2, 1, 1, "R9");
        sq_valid = 1; sq_tid = 2; sq_seq = 5;
        ins_valid = 1; ins_tid = 2; ins_seq = 8; ins_payload = PAY_W'(pay_of(2, 8));
        #1;
        check("R9", "younger append dropped", int'(ins_accepted), 0);
        tick();
        check("R9", "occupancy after drop", int'(occupancy), 1);
        sq_valid = 1; sq_tid = 2; sq_seq = 5;
        ins_valid = 1; ins_tid = 2; ins_seq = 5; ins_payload = PAY_W'(pay_of(2, 5));
        #1;
        check("R9", "append at squash point kept", int'(ins_accepted), 1);
        tick();
        sq_valid = 1; sq_tid = 2; sq_seq = 0;
        ins_valid = 1; ins_tid = 3; ins_seq = 200; ins_payload = PAY_W'(pay_of(3, 200));
        #1;
        check("R9", "other thread append kept", int'(ins_accepted), 1);
        tick();
        exp_tid[0] = 3; exp_seq[0] = 200;
        drain(1, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_fill();
        t_remove();
        t_squash();
        t_squash_insert();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule